// File: doc/BRIEF.md
# Fetch Target Predictor (direct-mapped branch target buffer)

This block predicts where fetch goes next, before the fetched instruction has been decoded. A table of 2^IDX_W entries is indexed by the fetch PC bits just above the two-bit word offset. Each entry holds a valid flag, the complete PC of a control-transfer instruction, and the target it last went to. When the indexed entry is valid and its stored PC equals the fetch PC, the stored target becomes the predicted next PC. In every other case the prediction is the sequential address PC+4. The lookup is combinational, so the prediction is available in the same cycle as the fetch PC.

The table is written only from branch resolution in the execute stage, through a single update port. A resolved taken branch or jump fills its indexed slot and displaces whatever instruction held it before. A resolved not-taken branch that owns its slot clears it, so later fetches fall through. Non-control instructions never reach the port. Because only taken transfers are ever stored, a hit also means "this is a taken branch". Because the whole PC is compared, two instructions that share an index never redirect each other.

Top module: `fetch_target_buf`

## Requirements
- R1: After reset every entry is invalid: pred_hit is 0 and pred_next_pc equals fetch_pc+4 for any fetch_pc until an entry is filled.
- R2: When the entry selected by fetch_pc is valid and its stored PC equals fetch_pc, pred_hit is 1 and pred_next_pc equals the stored target, in the same cycle.
- R3: When the selected entry is invalid or holds a different PC, pred_hit is 0 and pred_next_pc equals fetch_pc+4.
- R4: The entry index is fetch_pc[IDX_W+1:2] (bits 8 down to 2 by default); PCs that differ only above bit IDX_W+1 share one entry.
- R5: An update with upd_valid=1 and upd_taken=1 stores upd_pc and upd_target in entry upd_pc[IDX_W+1:2] and marks it valid; a lookup of upd_pc hits from the cycle after the clock edge that samples the update.
- R6: A taken update overwrites an entry held by a different PC with the same index; the old PC then misses.
- R7: An update with upd_valid=1 and upd_taken=0 whose upd_pc equals the PC stored in a valid entry invalidates that entry.
- R8: A not-taken update whose upd_pc differs from the stored PC leaves the entry unchanged.
- R9: While upd_valid is 0, upd_pc, upd_taken and upd_target have no effect on the table.
- R10: A lookup in the same cycle as an update to its entry returns the entry's contents from before that update.
- R11: The fall-through address wraps modulo 2^PC_W (fetch_pc 0xFFFFFFFC predicts 0x00000000 on a miss).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| pred_hit | output | 1 | High when the prediction comes from a stored entry |
| upd_valid | input | 1 | A resolved control-transfer instruction is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved instruction |
| upd_taken | input | 1 | Resolved direction: 1 taken, 0 not taken |
| upd_target | input | PC_W | Resolved target address of a taken transfer |

## Verification
The prediction is a pure function of fetch_pc and the table, so it is due in the cycle fetch_pc is applied; the bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. An update takes effect at the rising edge that samples it and is first visible to the lookup in the following cycle, so the reference model applies each update only after the check of the cycle in which it was driven, which also covers the old-contents rule of R10. Reset release passes through two synchronizing flops, and the bench waits three clocks after deasserting rst_n before the first check.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

  localparam int unsigned WORD_OFS = 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_FILL = 2'd1,
    ACT_DROP = 2'd2
  } ftb_act_e;

endpackage

// File: rtl/ftb_rst_sync.sv
module ftb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ftb_entry_array.sv
module ftb_entry_array #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_set,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [PC_W-1:0]  wr_tgt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PC_W-1:0]  rd_tag,
  output logic [PC_W-1:0]  rd_tgt,
  input  logic [IDX_W-1:0] ck_idx,
  output logic             ck_valid,
  output logic [PC_W-1:0]  ck_tag
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]           valid_all;
  logic [DEPTH-1:0][PC_W-1:0] tag_all;
  logic [DEPTH-1:0][PC_W-1:0] tgt_all;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic            sel;
    logic            vld_en;
    logic            dat_en;
    logic            vld_d;
    logic            vld_q;
    logic [PC_W-1:0] tag_q;
    logic [PC_W-1:0] tgt_q;

    always_comb begin
      sel    = wr_en && (wr_idx == IDX_W'(g));
      vld_en = sel;
      dat_en = sel && wr_set;
      vld_d  = wr_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q <= 1'b0;
      else if (vld_en) vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (dat_en) begin
        tag_q <= wr_pc;
        tgt_q <= wr_tgt;
      end
    end

    assign valid_all[g] = vld_q;
    assign tag_all[g]   = tag_q;
    assign tgt_all[g]   = tgt_q;
  end

  always_comb begin
    rd_valid = valid_all[rd_idx];
    rd_tag   = tag_all[rd_idx];
    rd_tgt   = tgt_all[rd_idx];
    ck_valid = valid_all[ck_idx];
    ck_tag   = tag_all[ck_idx];
  end

endmodule

// File: rtl/ftb_hit_logic.sv
module ftb_hit_logic #(
  parameter int unsigned PC_W = 32
) (
  input  logic            ent_valid,
  input  logic [PC_W-1:0] ent_tag,
  input  logic [PC_W-1:0] ent_tgt,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            hit,
  output logic [PC_W-1:0] next_pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [PC_W-1:0] seq_pc;

  always_comb begin
    seq_pc  = fetch_pc + STEP;
    hit     = ent_valid && (ent_tag == fetch_pc);
    next_pc = hit ? ent_tgt : seq_pc;
  end

endmodule

// File: rtl/ftb_update_ctl.sv
module ftb_update_ctl
  import ftb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 7
) (
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  input  logic             ck_valid,
  input  logic [PC_W-1:0]  ck_tag,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_en,
  output logic             wr_set
);

  ftb_act_e act;

  always_comb begin
    wr_idx = upd_pc[WORD_OFS +: IDX_W];
    act    = ACT_NONE;
    if (upd_valid) begin
      if (upd_taken)                            act = ACT_FILL;
      else if (ck_valid && (ck_tag == upd_pc))  act = ACT_DROP;
    end
    wr_en  = (act != ACT_NONE);
    wr_set = (act == ACT_FILL);
  end

endmodule

// File: rtl/fetch_target_buf.sv
module fetch_target_buf
  import ftb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_next_pc,
  output logic            pred_hit,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);

  logic             rst_sync_n;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_valid;
  logic [PC_W-1:0]  rd_tag;
  logic [PC_W-1:0]  rd_tgt;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en;
  logic             wr_set;
  logic             ck_valid;
  logic [PC_W-1:0]  ck_tag;

  assign rd_idx = fetch_pc[WORD_OFS +: IDX_W];

  ftb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ftb_entry_array #(.PC_W(PC_W), .IDX_W(IDX_W)) u_arr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_set   (wr_set),
    .wr_idx   (wr_idx),
    .wr_pc    (upd_pc),
    .wr_tgt   (upd_target),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_tgt   (rd_tgt),
    .ck_idx   (wr_idx),
    .ck_valid (ck_valid),
    .ck_tag   (ck_tag)
  );

  ftb_update_ctl #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd (
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken),
    .ck_valid  (ck_valid),
    .ck_tag    (ck_tag),
    .wr_idx    (wr_idx),
    .wr_en     (wr_en),
    .wr_set    (wr_set)
  );

  ftb_hit_logic #(.PC_W(PC_W)) u_hit (
    .ent_valid (rd_valid),
    .ent_tag   (rd_tag),
    .ent_tgt   (rd_tgt),
    .fetch_pc  (fetch_pc),
    .hit       (pred_hit),
    .next_pc   (pred_next_pc)
  );

endmodule

// File: rtl/ftb_checker.sv
module ftb_checker #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_sync_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            pred_hit,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) past_ok <= 1'b0;
    else             past_ok <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_no_hit: assert (!pred_hit);
    end
  end

  a_r3_miss_falls_through: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pred_hit |-> (pred_next_pc == fetch_pc + PC_W'(4)));

  a_r5_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_sync_n || !past_ok)
    ($past(upd_valid && upd_taken) && (fetch_pc == $past(upd_pc)))
      |-> (pred_hit && (pred_next_pc == $past(upd_target))));

  a_r7_not_taken_misses: assert property (@(posedge clk) disable iff (!rst_sync_n || !past_ok)
    ($past(upd_valid && !upd_taken) && (fetch_pc == $past(upd_pc))) |-> !pred_hit);

  a_r9_idle_keeps_output: assert property (@(posedge clk) disable iff (!rst_sync_n || !past_ok)
    (!$past(upd_valid) && $stable(fetch_pc)) |-> ($stable(pred_next_pc) && $stable(pred_hit)));

endmodule

bind fetch_target_buf ftb_checker #(.PC_W(PC_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_sync_n   (rst_sync_n),
  .fetch_pc     (fetch_pc),
  .pred_next_pc (pred_next_pc),
  .pred_hit     (pred_hit),
  .upd_valid    (upd_valid),
  .upd_pc       (upd_pc),
  .upd_taken    (upd_taken),
  .upd_target   (upd_target)
);

// File: tb/fetch_target_buf_tb_top.sv
`timescale 1ns/1ps
module fetch_target_buf_tb_top;

  localparam int unsigned PC_W  = 32;
  localparam int unsigned IDX_W = 7;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PC_W-1:0] fetch_pc;
  logic [PC_W-1:0] pred_next_pc;
  logic            pred_hit;
  logic            upd_valid;
  logic [PC_W-1:0] upd_pc;
  logic            upd_taken;
  logic [PC_W-1:0] upd_target;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic            m_vld [DEPTH];
  logic [PC_W-1:0] m_tag [DEPTH];
  logic [PC_W-1:0] m_tgt [DEPTH];

  always #2.5 clk = ~clk;

  fetch_target_buf #(.PC_W(PC_W), .IDX_W(IDX_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_next_pc (pred_next_pc),
    .pred_hit     (pred_hit),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target)
  );

  function automatic int unsigned idx_of(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic m_hit(logic [PC_W-1:0] pc);
    return m_vld[idx_of(pc)] && (m_tag[idx_of(pc)] == pc);
  endfunction

  function automatic logic [PC_W-1:0] m_next(logic [PC_W-1:0] pc);
    return m_hit(pc) ? m_tgt[idx_of(pc)] : pc + PC_W'(4);
  endfunction

  task automatic check(string req, logic [PC_W-1:0] got, logic [PC_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_apply(logic uv, logic [PC_W-1:0] upc, logic ut, logic [PC_W-1:0] utgt);
    int unsigned i;
    i = idx_of(upc);
    if (uv) begin
      if (ut) begin
        m_vld[i] = 1'b1;
        m_tag[i] = upc;
        m_tgt[i] = utgt;
      end else if (m_vld[i] && m_tag[i] == upc) begin
        m_vld[i] = 1'b0;
      end
    end
  endtask

  task automatic step(string req, logic [PC_W-1:0] pc, logic uv,
                      logic [PC_W-1:0] upc, logic ut, logic [PC_W-1:0] utgt);
    @(negedge clk);
    fetch_pc   = pc;
    upd_valid  = uv;
    upd_pc     = upc;
    upd_taken  = ut;
    upd_target = utgt;
    #1;
    check(req, pred_next_pc, m_next(pc));
    check(req, PC_W'(pred_hit), PC_W'(m_hit(pc)));
    model_apply(uv, upc, ut, utgt);
  endtask

  task automatic look(string req, logic [PC_W-1:0] pc);
    step(req, pc, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  function automatic logic [PC_W-1:0] rand_pc();
    logic [22:0] hi;
    logic [6:0]  ix;
    case ($urandom_range(0, 2))
      0:       hi = 23'h000000;
      1:       hi = 23'h000001;
      default: hi = 23'h7FFFFF;
    endcase
    ix = 7'($urandom_range(0, 7));
    return {hi, ix, 2'b00};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 1'b0;
      m_tag[i] = '0;
      m_tgt[i] = '0;
    end
    rst_n      = 1'b0;
    fetch_pc   = '0;
    upd_valid  = 1'b0;
    upd_pc     = '0;
    upd_taken  = 1'b0;
    upd_target = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset hit", PC_W'(pred_hit), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: empty table after reset
    look("R1", 32'h0000_0000);
    look("R1", 32'h0000_1000);
    // R11: wrap of fall-through
    look("R11", 32'hFFFF_FFFC);

    // R5: fill, then hit in the following cycle
    step("R5", 32'h0000_0040, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_2000);
    look("R5 R2", 32'h0000_0100);
    // R4: same index 64, different upper bits -> miss; neighbouring index -> miss
    look("R4 R3", 32'h0000_0300);
    look("R4", 32'h0000_0104);

    // R6: aliasing taken update displaces the old owner
    step("R6", 32'h0000_0040, 1'b1, 32'h0000_0300, 1'b1, 32'h0000_4000);
    look("R6 old", 32'h0000_0100);
    look("R6 new", 32'h0000_0300);

    // R8: not-taken update with a non-owning PC changes nothing
    step("R8", 32'h0000_0040, 1'b1, 32'h0000_0100, 1'b0, 32'h0);
    look("R8", 32'h0000_0300);

    // R7: not-taken update by the owner invalidates
    step("R7", 32'h0000_0040, 1'b1, 32'h0000_0300, 1'b0, 32'h0);
    look("R7", 32'h0000_0300);

    // R10: lookup during a write to its entry sees old contents
    step("R10", 32'h0000_0040, 1'b1, 32'h0000_0500, 1'b1, 32'h0000_0600);
    step("R10 old", 32'h0000_0500, 1'b1, 32'h0000_0500, 1'b1, 32'h0000_0700);
    look("R10 new", 32'h0000_0500);

    // R9: update fields with upd_valid low have no effect
    @(negedge clk);
    fetch_pc   = 32'h0000_0500;
    upd_valid  = 1'b0;
    upd_pc     = 32'h0000_0500;
    upd_taken  = 1'b1;
    upd_target = 32'hDEAD_BEE0;
    @(negedge clk);
    upd_taken  = 1'b0;
    @(negedge clk);
    #1;
    check("R9", pred_next_pc, 32'h0000_0700);
    check("R9 hit", PC_W'(pred_hit), PC_W'(1));

    // R11/R2: entry at the top of the address space
    step("R11", 32'h0000_0040, 1'b1, 32'hFFFF_FFFC, 1'b1, 32'h0000_0010);
    look("R11 R2", 32'hFFFF_FFFC);

    // Random mix over a small PC pool to force hits and aliasing
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] p;
      logic [PC_W-1:0] u;
      logic [PC_W-1:0] t;
      logic            v;
      logic            tk;
      p  = rand_pc();
      u  = rand_pc();
      t  = {$urandom()} & 32'hFFFF_FFFC;
      v  = ($urandom_range(0, 1) == 1);
      tk = ($urandom_range(0, 9) < 6);
      step(m_hit(p) ? "R2 random" : "R3 random", p, v, u, tk, t);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule